// File: doc/BRIEF.md
# Prefetching Host Read Port with Control-Word Exclusion

This block is a host-side access port in front of a 16-bit internal RAM. Host reads normally pay the RAM read latency, and the port stretches them with `wait_o`. When a RAM read completes, the port speculatively fetches the next sequential word into a one-entry buffer. If the host's next read asks for exactly that word, the read finishes in the short cycle with no wait state.

A relocatable 512-word descriptor table lives in the same RAM. Its start address is held in a host-writable register. Inside the table, the first word and every fourth word after it hold a control word. Bit 15 of a control word is a status flag that any host read clears. A speculative read must therefore never touch a control word. The port withholds the prefetch whenever the next address is such a word. As a result, a sequential run through the table pays the slow cycle on every fourth word.

Requests use a simple hold-until-acknowledge handshake. The host raises `req_i` with the address, the direction and the register/RAM select, and holds them until `ack_o` pulses for one cycle.

Top module: `hrp_host_port`

## Requirements
- R1: While reset is asserted and after it is released, `ack_o`, `wait_o` and `rdata_o` are 0, the table base is 0, and no prefetched word is held.
- R2: A RAM write (`reg_i`=0, `we_i`=1) stores `wdata_i` at `addr_i`. It raises `ack_o` in the cycle after the request is sampled, and `wait_o` stays low throughout.
- R3: With `reg_i`=1, register address 5 holds the table base (the low ADDR_W bits of the written data). Reading it returns the base zero-extended, and every other register address reads 0. Register accesses acknowledge after one cycle with no wait, and a register write other than the base write leaves a held prefetch intact.
- R4: A RAM read that is not served from the prefetch buffer drives `wait_o` high from the request cycle until the acknowledge. `ack_o` rises RD_LAT+1 cycles (3 by default) after the request is sampled and is a single-cycle pulse, with `rdata_o` equal to the stored word.
- R5: After a host read of address A completes, a following read of A+1 that starts after one idle cycle completes with `wait_o` low and `ack_o` in the next cycle, and returns the stored word. This holds provided the prefetch of A+1 was allowed and not discarded.
- R6: Address X is a control word when off = (X - base) mod 2^ADDR_W satisfies off < 512 and off mod 4 = 0. A control word is never fetched speculatively, so reading it right after X-1 takes the slow path.
- R7: A sequential read run through the table takes the slow path on every word whose offset is a multiple of 4, and the fast path on the others (after the first read).
- R8: A host read of a control word returns the stored value and then clears bit 15 of that word in RAM. Reads of other words and prefetches modify nothing.
- R9: A host RAM read of any address other than the prefetched one discards the prefetch.
- R10: A RAM write to the prefetched address discards the prefetch, so the next read of it is slow and returns the new data. A write to any other address keeps the prefetch.
- R11: No prefetch is issued past address 2^ADDR_W-1, so a read of address 0 after the top address is slow. Addresses outside the table are always eligible.
- R12: Writing the table base register discards any held or pending prefetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_i | input | 1 | 1 = register space, 0 = RAM |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| wait_o | output | 1 | Stretch request for slow accesses |
| rdata_o | output | DATA_W | Read data, valid with `ack_o` |

## Verification
The bound checker watches the following on every cycle:
- every speculative RAM read and every held prefetch address stays off the control words of the current table;
- status-bit clears hit only control words;
- no speculative read wraps to address 0;
- `ack_o` is a single pulse;
- any request left without wait is acknowledged in the next cycle.

Only the bench's scenarios can show the history-dependent behaviour:
- fast versus slow timing across sequential runs inside, across and outside the table;
- the one-shot clearing of the status bit;
- the discard rules for reads, writes and base relocation;
- the table wrapping past the top of memory.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_RESP = 2'd2
  } st_e;
endpackage

// File: rtl/hrp_cw_decode.sv
module hrp_cw_decode #(
  parameter int ADDR_W    = 10,
  parameter int TBL_WORDS = 512,
  parameter int CW_STRIDE = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_cw_o
);
  localparam int SW = $clog2(CW_STRIDE);

  logic [ADDR_W-1:0] off;
  logic              in_tbl;

  assign off     = addr_i - base_i;
  assign in_tbl  = {1'b0, off} < (ADDR_W+1)'(TBL_WORDS);
  assign is_cw_o = in_tbl && (off[SW-1:0] == '0);
endmodule

// File: rtl/hrp_ram.sv
module hrp_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic              rtag_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rvld_o,
  output logic              rtag_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [RD_LAT-1:0] vld_q, tag_q;
  logic [ADDR_W-1:0] adr_q [RD_LAT];
  logic [DATA_W-1:0] dat_q [RD_LAT];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // tagged latency pipe: tag 1 marks speculative reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q[0] <= re_i;
      tag_q[0] <= rtag_i;
      for (int s = 1; s < RD_LAT; s++) begin
        vld_q[s] <= vld_q[s-1];
        tag_q[s] <= tag_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (re_i) begin
      adr_q[0] <= raddr_i;
      dat_q[0] <= mem_q[raddr_i];
    end
    for (int s = 1; s < RD_LAT; s++) begin
      adr_q[s] <= adr_q[s-1];
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign rvld_o  = vld_q[RD_LAT-1];
  assign rtag_o  = tag_q[RD_LAT-1];
  assign raddr_o = adr_q[RD_LAT-1];
  assign rdata_o = dat_q[RD_LAT-1];
endmodule

// File: rtl/hrp_host_port.sv
module hrp_host_port import hrp_pkg::*; #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int TBL_WORDS = 512,
  parameter int CW_STRIDE = 4,
  parameter int RD_LAT    = 2,
  parameter int STAT_BIT  = 15,
  parameter int BASE_REG  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              reg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              wait_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
  localparam logic [DATA_W-1:0] CLR_MASK = ~(DATA_W'(1) << STAT_BIT);

  st_e               st_q;
  logic [ADDR_W-1:0] base_q, cur_q, pf_addr_q;
  logic              pf_vld_q, pf_pend_q;
  logic [DATA_W-1:0] pf_data_q, rdata_q;

  logic              ram_we, ram_re, ram_rtag;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata;
  logic              ram_rvld, ram_otag;
  logic [ADDR_W-1:0] ram_oaddr;
  logic [DATA_W-1:0] ram_odata;

  logic              idle_req, ram_rd_req, ram_wr_req, base_wr;
  logic              pf_land, hit_buf, hit_byp, pf_hit, dem_done, commit;
  logic [ADDR_W-1:0] commit_addr, nxt_addr;
  logic              cur_is_cw, nxt_is_cw, pf_ok;
  logic [DATA_W-1:0] reg_rdata;

  hrp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_ram (
    .clk_i, .rst_ni,
    .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .re_i(ram_re), .rtag_i(ram_rtag), .raddr_i(ram_raddr),
    .rvld_o(ram_rvld), .rtag_o(ram_otag), .raddr_o(ram_oaddr), .rdata_o(ram_odata)
  );

  hrp_cw_decode #(.ADDR_W(ADDR_W), .TBL_WORDS(TBL_WORDS), .CW_STRIDE(CW_STRIDE)) u_cw_cur (
    .base_i(base_q), .addr_i(cur_q), .is_cw_o(cur_is_cw)
  );

  hrp_cw_decode #(.ADDR_W(ADDR_W), .TBL_WORDS(TBL_WORDS), .CW_STRIDE(CW_STRIDE)) u_cw_nxt (
    .base_i(base_q), .addr_i(nxt_addr), .is_cw_o(nxt_is_cw)
  );

  assign idle_req   = (st_q == ST_IDLE) && req_i;
  assign ram_rd_req = idle_req && !reg_i && !we_i;
  assign ram_wr_req = idle_req && !reg_i && we_i;
  assign base_wr    = idle_req && reg_i && we_i && (addr_i == ADDR_W'(BASE_REG));

  // speculative word arriving this cycle can serve the request directly
  assign pf_land  = pf_pend_q && ram_rvld && ram_otag && (ram_oaddr == pf_addr_q);
  assign hit_buf  = pf_vld_q && (pf_addr_q == addr_i);
  assign hit_byp  = pf_land && (pf_addr_q == addr_i);
  assign pf_hit   = ram_rd_req && (hit_buf || hit_byp);
  assign dem_done = (st_q == ST_RD) && ram_rvld && !ram_otag;
  assign commit   = pf_hit || dem_done;

  assign commit_addr = (st_q == ST_IDLE) ? addr_i : cur_q;
  assign nxt_addr    = commit_addr + 1'b1;
  assign pf_ok       = commit && (commit_addr != ADDR_TOP) && !nxt_is_cw;

  assign ram_we    = ram_wr_req || (dem_done && cur_is_cw);
  assign ram_waddr = ram_wr_req ? addr_i : cur_q;
  assign ram_wdata = ram_wr_req ? wdata_i : (ram_odata & CLR_MASK);
  assign ram_re    = (ram_rd_req && !pf_hit) || pf_ok;
  assign ram_rtag  = pf_ok;
  assign ram_raddr = pf_ok ? nxt_addr : addr_i;

  assign reg_rdata = (addr_i == ADDR_W'(BASE_REG)) ? DATA_W'(base_q) : '0;

  assign ack_o   = (st_q == ST_RESP);
  assign wait_o  = req_i && !ack_o && !((st_q == ST_IDLE) && (reg_i || we_i || pf_hit));
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      rdata_q <= '0;
      base_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          if (ram_rd_req && !pf_hit) begin
            st_q  <= ST_RD;
            cur_q <= addr_i;
          end else begin
            st_q <= ST_RESP;
          end
          if (reg_i && !we_i) rdata_q <= reg_rdata;
          if (pf_hit)         rdata_q <= hit_buf ? pf_data_q : ram_odata;
          if (base_wr)        base_q  <= wdata_i[ADDR_W-1:0];
        end
        ST_RD: if (dem_done) begin
          st_q    <= ST_RESP;
          rdata_q <= ram_odata;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_vld_q  <= 1'b0;
      pf_pend_q <= 1'b0;
      pf_addr_q <= '0;
      pf_data_q <= '0;
    end else begin
      if (pf_land) begin
        pf_vld_q  <= 1'b1;
        pf_pend_q <= 1'b0;
        pf_data_q <= ram_odata;
      end
      if (ram_rd_req || base_wr || (ram_wr_req && (addr_i == pf_addr_q))) begin
        pf_vld_q  <= 1'b0;
        pf_pend_q <= 1'b0;
      end
      if (pf_ok) begin
        pf_vld_q  <= 1'b0;
        pf_pend_q <= 1'b1;
        pf_addr_q <= nxt_addr;
      end
    end
  end
endmodule

// File: rtl/hrp_host_port_chk.sv
module hrp_host_port_chk import hrp_pkg::*; #(
  parameter int ADDR_W    = 10,
  parameter int TBL_WORDS = 512,
  parameter int CW_STRIDE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ack_o,
  input logic              wait_o,
  input st_e               st_q,
  input logic [ADDR_W-1:0] base_q,
  input logic              ram_re,
  input logic              ram_rtag,
  input logic [ADDR_W-1:0] ram_raddr,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_waddr,
  input logic              pf_vld_q,
  input logic [ADDR_W-1:0] pf_addr_q
);
  localparam int SW = $clog2(CW_STRIDE);

  function automatic logic is_cw(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - base_q;
    return ({1'b0, off} < (ADDR_W+1)'(TBL_WORDS)) && (off[SW-1:0] == '0);
  endfunction

  // R6
  no_cw_prefetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re && ram_rtag) |-> !is_cw(ram_raddr));

  // R6
  held_pf_not_cw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_vld_q |-> !is_cw(pf_addr_q));

  // R8
  clear_only_cw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && st_q == ST_RD) |-> is_cw(ram_waddr));

  // R11
  no_wrap_pf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re && ram_rtag) |-> (ram_raddr != '0));

  // R4
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R5
  fast_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wait_o && !ack_o) |=> ack_o);
endmodule

bind hrp_host_port hrp_host_port_chk #(
  .ADDR_W(ADDR_W), .TBL_WORDS(TBL_WORDS), .CW_STRIDE(CW_STRIDE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ack_o(ack_o), .wait_o(wait_o),
  .st_q(st_q), .base_q(base_q), .ram_re(ram_re), .ram_rtag(ram_rtag),
  .ram_raddr(ram_raddr), .ram_we(ram_we), .ram_waddr(ram_waddr),
  .pf_vld_q(pf_vld_q), .pf_addr_q(pf_addr_q)
);

// File: tb/hrp_host_port_test.sv
`timescale 1ns/1ps
module hrp_host_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, rsel;
  logic [9:0]  addr;
  logic [15:0] wdata;
  logic        ack, wt;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mem_m [1024];
  logic [9:0]  base_m;
  bit          pf_v;
  logic [9:0]  pf_a;

  always #2 clk = ~clk;

  hrp_host_port uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .reg_i(rsel),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .wait_o(wt), .rdata_o(rdata)
  );

  function automatic bit m_cw(logic [9:0] a);
    logic [9:0] off;
    off = a - base_m;
    return (off < 10'd512) && (off[1:0] == 2'b00);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one host access; starts and ends at a falling edge
  task automatic acc(string tag, bit r, bit w, logic [9:0] a, logic [15:0] d);
    bit fast;
    logic [15:0] exp_d;
    int lat;
    exp_d = '0;
    if (r) begin
      fast = 1;
      if (!w && a == 10'd5) exp_d = {6'b0, base_m};
      if (w && a == 10'd5) begin base_m = d[9:0]; pf_v = 0; end
    end else if (w) begin
      fast = 1;
      mem_m[a] = d;
      if (pf_v && pf_a == a) pf_v = 0;
    end else begin
      fast  = pf_v && (pf_a == a);
      exp_d = mem_m[a];
      if (m_cw(a)) mem_m[a] = exp_d & 16'h7fff;
      if (a != 10'h3ff && !m_cw(a + 10'd1)) begin pf_v = 1; pf_a = a + 10'd1; end
      else pf_v = 0;
    end
    lat = fast ? 1 : 3;
    req = 1; we = w; rsel = r; addr = a; wdata = d;
    #1;
    for (int k = 0; k < lat; k++) begin
      chk(ack == 1'b0, tag, "ack early", ack, 0);
      chk(wt == !fast, tag, "wait", wt, !fast);
      @(negedge clk); #1;
    end
    chk(ack == 1'b1, tag, "ack", ack, 1);
    chk(wt == 1'b0, tag, "wait at ack", wt, 0);
    if (!w) chk(rdata == exp_d, tag, "rdata", rdata, exp_d);
    req = 0; we = 0; rsel = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R4 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req = 0; we = 0; rsel = 0; addr = '0; wdata = '0;
    base_m = '0; pf_v = 0; pf_a = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ack == 0 && wt == 0 && rdata == 0, "R1", "reset outputs", {ack, wt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ack == 0 && wt == 0 && rdata == 0, "R1", "post reset outputs", {ack, wt}, 0);
    acc("R1", 1, 0, 10'd5, 0);                // base reads 0

    for (int a = 0; a < 1024; a++)
      acc("R2", 0, 1, 10'(a), 16'h8000 | 16'((a * 37) & 16'h7fff));

    acc("R3", 1, 0, 10'd7, 0);                // other reg reads 0

    for (int a = 600; a < 608; a++) acc("R5", 0, 0, 10'(a), 0);

    for (int a = 0; a < 13; a++) acc("R7", 0, 0, 10'(a), 0);

    acc("R8", 0, 0, 10'd0, 0);                // status bit now clear
    acc("R8", 0, 0, 10'd4, 0);
    acc("R8", 0, 0, 10'd1, 0);
    acc("R8", 0, 0, 10'd1, 0);                // non-control word unchanged

    acc("R9", 0, 0, 10'd700, 0);
    acc("R9", 0, 0, 10'd800, 0);
    acc("R9", 0, 0, 10'd701, 0);              // slow: discarded

    acc("R10", 0, 0, 10'd710, 0);
    acc("R10", 0, 1, 10'd711, 16'h1234);
    acc("R10", 0, 0, 10'd711, 0);             // slow, new data
    acc("R10", 0, 0, 10'd720, 0);
    acc("R10", 0, 1, 10'd900, 16'h0abc);
    acc("R10", 0, 0, 10'd721, 0);             // fast: kept

    acc("R12", 0, 0, 10'd730, 0);
    acc("R12", 1, 1, 10'd5, 16'd100);
    acc("R12", 0, 0, 10'd731, 0);             // slow after base write
    acc("R3", 1, 0, 10'd5, 0);                // reads 100

    acc("R3", 0, 0, 10'd850, 0);
    acc("R3", 1, 1, 10'd3, 16'hffff);
    acc("R3", 0, 0, 10'd851, 0);              // fast: kept
    acc("R3", 1, 0, 10'd5, 0);                // base untouched

    acc("R11", 0, 0, 10'd1022, 0);
    acc("R11", 0, 0, 10'd1023, 0);
    acc("R11", 0, 0, 10'd0, 0);               // slow: no wrap prefetch
    acc("R11", 0, 0, 10'd1, 0);

    acc("R6", 1, 1, 10'd5, 16'd1000);          // table wraps past top
    for (int a = 1002; a < 1007; a++) acc("R6", 0, 0, 10'(a), 0);
    acc("R6", 0, 0, 10'd2, 0);
    acc("R6", 0, 0, 10'd3, 0);
    acc("R6", 0, 0, 10'd4, 0);                // offset 28: slow
    acc("R6", 0, 0, 10'd5, 0);
    acc("R8", 0, 0, 10'd4, 0);                // cleared by the read above

    acc("R6", 1, 1, 10'd5, 16'd0);
    for (int a = 508; a < 515; a++) acc("R6", 0, 0, 10'(a), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule